// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter with Clear-to-Send Hold-Off

This block serializes words onto one transmit line as asynchronous frames. A word is written into a single holding buffer. As soon as the shifter is free it moves into the shifter. While that frame is on the line, the next word can already wait in the buffer. Each frame is a low start bit, followed by 7, 8 or 9 data bits sent least significant bit first. An even or odd parity bit can follow, and the frame ends with one or two high stop bits. Each bit lasts 16*(n+1) clock cycles, where n is the divider input.

An optional clear-to-send input holds off new frames. It is resynchronized through a flop chain and examined only where a frame could begin: while the line is idle, and at the end of the last stop bit. A frame that has already started always completes. Two status outputs report that the holding buffer is empty and that the shifter has gone idle. A sticky interrupt line is raised by one of two events, picked by a select input:

- the word leaving the buffer, or
- the shifter going empty.

The interrupt stays set until it is cleared.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `reg_empty` is 1 and `irq` is 0.
- R2: Every bit on `txd` lasts exactly 16*(`baud_div`+1) clock cycles, and `txd` changes only at those bit boundaries.
- R3: A frame starts with a 0 bit, followed by the data bits least significant first. The data bit count comes from `cfg_len`: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 gives 9 bits. Write-data bits above that count are not sent.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd`=0 it is the XOR of the sent data bits (even parity). With `cfg_par_odd`=1 it is the inverse of that XOR (odd parity).
- R5: The frame ends with one stop bit of value 1, or two when `cfg_stop2` is 1.
- R6: A write with `wr_en` to an empty buffer drives `buf_empty` to 0 after that edge. If the shifter is idle, transmit is enabled and CTS permits, the word moves to the shifter on the next edge. At that edge `txd` goes to 0 and `buf_empty` returns to 1.
- R7: A write while the buffer is full is dropped: the buffered word is kept and the dropped word never appears on `txd`.
- R8: `reg_empty` falls when a frame is loaded. It rises on the edge that ends the last stop bit if no word follows. If a word is waiting and allowed to go, its start bit begins on that same edge with no idle gap and `reg_empty` stays 0.
- R9: With `cfg_cts_en`=1 and `cts`=1, no new frame starts; a frame in progress completes. After `cts` falls, a waiting word starts on the third rising edge.
- R10: With `cfg_tx_en`=0, no new frame starts, the frame in progress completes, and a buffered word waits until `cfg_tx_en` returns to 1.
- R11: With `cfg_irq_sel`=0, `irq` is set on the edge that moves a word from buffer to shifter. With `cfg_irq_sel`=1, it is set on the edge where `reg_empty` rises. Once set, `irq` stays 1 until a cycle with `irq_clr`=1. A set event wins over a simultaneous clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to transmit |
| cfg_tx_en | input | 1 | Allows new frames to start |
| cfg_len | input | 2 | Data length select (0:7, 1:8, 2/3:9 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_cts_en | input | 1 | Enables clear-to-send hold-off |
| cfg_irq_sel | input | 1 | Interrupt cause: 0 buffer empty, 1 shifter empty |
| baud_div | input | 8 | Divider value n; bit time 16*(n+1) cycles |
| irq_clr | input | 1 | Clears the interrupt request |
| cts | input | 1 | Clear to send, active low, asynchronous |
| txd | output | 1 | Serial transmit line, idles high |
| buf_empty | output | 1 | Holding buffer is empty |
| reg_empty | output | 1 | Shifter is idle |
| irq | output | 1 | Sticky interrupt request |

## Verification
On every cycle, the embedded assertions check a set of invariants:

- the line is high whenever the shifter reports empty;
- `txd` holds still between bit ticks;
- a load always drives the start bit low;
- a full buffer keeps its word until a transfer;
- neither a disabled transmitter nor an asserted CTS lets an idle shifter begin a frame;
- the interrupt stays set until cleared.

The bench scenarios show what a single-cycle property cannot:

- exact bit content for every length, parity and stop combination, and the parity value;
- the exact cycle of each edge for several divider values;
- gap-free chaining;
- that a dropped write never reaches the line;
- the three-edge CTS release latency;
- which event raises the interrupt under each select setting.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } frame_cfg_t;

  // Data bit count for a length code, relative to the widest word dw.
  function automatic int data_bits(input logic [1:0] len, input int dw);
    case (len)
      2'd0:    return dw - 2;
      2'd1:    return dw - 1;
      default: return dw;
    endcase
  endfunction

endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             bit_end
);
  localparam int CW = DIV_W + $clog2(OVS) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last    = CW'(OVS) * (CW'(div) + CW'(1)) - CW'(1);
  assign bit_end = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (bit_end)           cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/utx_frame.sv
module utx_frame
  import utx_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          bit_end,
  input  logic [DW-1:0] word,
  input  frame_cfg_t    cfg,
  output logic          txd,
  output logic          busy,
  output logic          at_end
);
  localparam int FW = DW + 4;
  localparam int LW = $clog2(FW + 1);

  logic [FW-1:0] vec;
  logic [LW-1:0] nbits;
  logic [FW-2:0] rest;
  logic [LW-1:0] left;

  // Assemble the whole frame, LSB goes out first.
  always_comb begin
    int  n;
    logic par;
    n   = data_bits(cfg.len, DW);
    par = cfg.par_odd;
    vec = '1;
    vec[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < n) begin
        vec[1+i] = word[i];
        par      = par ^ word[i];
      end
    end
    for (int j = DW - 2; j <= DW; j++) begin
      if (cfg.par_en && j == n) vec[1+j] = par;
    end
    nbits = LW'(2 + n + int'(cfg.par_en) + int'(cfg.stop2));
  end

  assign at_end = busy && bit_end && (left == LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= 1'b1;
      busy <= 1'b0;
      left <= '0;
      rest <= '1;
    end else if (load) begin
      txd  <= vec[0];
      rest <= vec[FW-1:1];
      left <= nbits;
      busy <= 1'b1;
    end else if (busy && bit_end) begin
      if (left == LW'(1)) begin
        txd  <= 1'b1;
        busy <= 1'b0;
        left <= '0;
      end else begin
        txd  <= rest[0];
        rest <= {1'b1, rest[FW-2:1]};
        left <= left - LW'(1);
      end
    end
  end

  a_r2_line_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_end && !load) |=> $stable(txd));

  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    load |=> (!txd && busy));

endmodule

// File: rtl/utx_irq.sv
module utx_irq (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic buf_evt,
  input  logic reg_evt,
  input  logic clr,
  output logic irq
);
  logic set_evt;
  assign set_evt = sel ? reg_evt : buf_evt;

  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (set_evt) irq <= 1'b1;
    else if (clr)     irq <= 1'b0;
  end

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq);

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import utx_pkg::*;
#(
  parameter int DW       = 9,
  parameter int DIV_W    = 8,
  parameter int OVS      = 16,
  parameter int CTS_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             cfg_tx_en,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_stop2,
  input  logic             cfg_cts_en,
  input  logic             cfg_irq_sel,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             irq_clr,
  input  logic             cts,
  output logic             txd,
  output logic             buf_empty,
  output logic             reg_empty,
  output logic             irq
);
  logic [CTS_SYNC-1:0] cts_q;
  logic                cts_hold;
  logic                buf_full;
  logic [DW-1:0]       buf_word;
  logic                busy;
  logic                at_end;
  logic                bit_end;
  logic                start;
  logic                reg_empty_q;
  frame_cfg_t          fcfg;

  // Clear-to-send resynchronizer.
  always_ff @(posedge clk) begin
    if (rst) cts_q <= '1;
    else begin
      cts_q[0] <= cts;
      for (int i = 1; i < CTS_SYNC; i++) cts_q[i] <= cts_q[i-1];
    end
  end
  assign cts_hold = cts_q[CTS_SYNC-1];

  // A frame may begin only from idle or exactly at the last stop boundary.
  assign start = buf_full && cfg_tx_en && !(cfg_cts_en && cts_hold) && (!busy || at_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      buf_word <= '0;
    end else if (start) begin
      buf_full <= 1'b0;
    end else if (wr_en && !buf_full) begin
      buf_full <= 1'b1;
      buf_word <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_empty_q <= 1'b1;
    else if (start)  reg_empty_q <= 1'b0;
    else if (at_end) reg_empty_q <= 1'b1;
  end

  assign fcfg      = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
  assign buf_empty = !buf_full;
  assign reg_empty = reg_empty_q;

  utx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .restart(start), .div(baud_div), .bit_end(bit_end)
  );

  utx_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst(rst), .load(start), .bit_end(bit_end), .word(buf_word), .cfg(fcfg),
    .txd(txd), .busy(busy), .at_end(at_end)
  );

  utx_irq u_irq (
    .clk(clk), .rst(rst), .sel(cfg_irq_sel), .buf_evt(start),
    .reg_evt(at_end && !start), .clr(irq_clr), .irq(irq)
  );

  a_r8_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    reg_empty_q |-> txd);

  a_r7_full_keeps_word: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !start) |=> (buf_full && $stable(buf_word)));

  a_r10_disabled_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (!cfg_tx_en && !busy) |=> !busy);

  a_r9_cts_stays_idle: assert property (@(posedge clk) disable iff (rst)
    (cfg_cts_en && cts_hold && !busy) |=> !busy);

endmodule

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       cfg_tx_en = 1'b1;
  logic [1:0] cfg_len = 2'd1;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic       cfg_cts_en = 1'b0, cfg_irq_sel = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic       irq_clr = 1'b0;
  logic       cts = 1'b0;
  logic       txd, buf_empty, reg_empty, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .cfg_tx_en(cfg_tx_en),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_cts_en(cfg_cts_en), .cfg_irq_sel(cfg_irq_sel),
    .baud_div(baud_div), .irq_clr(irq_clr), .cts(cts),
    .txd(txd), .buf_empty(buf_empty), .reg_empty(reg_empty), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [8:0] d, input int len, input int pm,
                                    input int s2, output logic [63:0] v, output int nb);
    int nd, ones, k;
    nd = (len == 0) ? 7 : (len == 1) ? 8 : 9;
    v = '1; ones = 0; k = 0;
    v[k] = 1'b0; k = k + 1;
    for (int i = 0; i < nd; i++) begin
      v[k] = d[i]; k = k + 1;
      if (d[i]) ones = ones + 1;
    end
    if (pm != 0) begin
      v[k] = (pm == 2) ? ((ones % 2) == 0) : ((ones % 2) == 1);
      k = k + 1;
    end
    nb = k + 1 + ((s2 != 0) ? 1 : 0);
  endfunction

  task automatic wr(input logic [8:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start(output int w);
    w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (txd !== 1'b0 && w < 5000);
  endtask

  task automatic capture(input int nb, input int per, input int first, output logic [63:0] v);
    v = '1;
    repeat (first) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      v[i] = txd;
      if (i != nb - 1) repeat (per) @(negedge clk);
    end
  endtask

  task automatic set_cfg(input int len, input int pm, input int s2, input int dv);
    cfg_len = 2'(len); cfg_par_en = (pm != 0); cfg_par_odd = (pm == 2);
    cfg_stop2 = (s2 != 0); baud_div = 8'(dv);
  endtask

  task automatic one_frame(input logic [8:0] d, input int len, input int pm, input int s2, input int dv);
    logic [63:0] ev, got;
    int nb, w, per;
    per = 16 * (dv + 1);
    set_cfg(len, pm, s2, dv);
    exp_frame(d, len, pm, s2, ev, nb);
    wr(d);
    chk("R6 buffer flag after write", 64'(buf_empty), 64'd0);
    wait_start(w);
    chk("R6 start one edge after write", 64'(w), 64'd1);
    chk("R6 buffer empty after transfer", 64'(buf_empty), 64'd1);
    capture(nb, per, per / 2, got);
    chk("R3 R4 R5 frame bits", got, ev);
    repeat (per / 2 - 1) @(negedge clk);
    chk("R8 register busy through last stop", 64'(reg_empty), 64'd0);
    @(negedge clk);
    chk("R2 register empty at exact frame end", 64'(reg_empty), 64'd1);
    chk("R8 line idle after frame", 64'(txd), 64'd1);
  endtask

  function automatic logic [63:0] lowmask(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not finish, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0]  vals [4];
    logic [63:0] ea, eb, got;
    int          na, nb, w, hi_low;
    vals[0] = 9'h000; vals[1] = 9'h1FF; vals[2] = 9'h0A5; vals[3] = 9'h15A;

    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 txd in reset", 64'(txd), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd", 64'(txd), 64'd1);
    chk("R1 buf_empty", 64'(buf_empty), 64'd1);
    chk("R1 reg_empty", 64'(reg_empty), 64'd1);
    chk("R1 irq", 64'(irq), 64'd0);

    // Sweep lengths, parity modes, stop counts and data patterns.
    for (int len = 0; len < 3; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int s2 = 0; s2 < 2; s2++)
          for (int vi = 0; vi < 4; vi++)
            one_frame(vals[vi], len, pm, s2, 0);
    one_frame(9'h133, 3, 1, 0, 0);   // R3 code 3 behaves as 9 bits
    // R2 other divider values
    one_frame(9'h0C3, 1, 2, 0, 1);
    one_frame(9'h1A6, 2, 1, 1, 3);

    // R8 back-to-back words, no idle gap
    set_cfg(1, 0, 0, 0);
    exp_frame(9'h03C, 1, 0, 0, ea, na);
    exp_frame(9'h0C5, 1, 0, 0, eb, nb);
    wr(9'h03C);
    wait_start(w);
    wr(9'h0C5);
    capture(na + nb, 16, 7, got);
    chk("R8 chained frames without gap", got & lowmask(na + nb),
        ((ea & lowmask(na)) | (eb << na)) & lowmask(na + nb));
    repeat (8) @(negedge clk);
    chk("R8 empty after chain", 64'(reg_empty), 64'd1);

    // R7 write while full is dropped
    exp_frame(9'h011, 1, 0, 0, ea, na);
    exp_frame(9'h0F0, 1, 0, 0, eb, nb);
    wr(9'h011);
    wait_start(w);
    wr(9'h0F0);
    wr(9'h0AA);
    capture(na + nb, 16, 6, got);
    chk("R7 buffered word kept", got & lowmask(na + nb),
        ((ea & lowmask(na)) | (eb << na)) & lowmask(na + nb));
    hi_low = 0;
    repeat (12 * 16) begin
      @(negedge clk);
      if (txd !== 1'b1) hi_low++;
    end
    chk("R7 dropped word never sent", 64'(hi_low), 64'd0);
    chk("R7 buffer empty afterwards", 64'(buf_empty), 64'd1);

    // R9 clear-to-send hold-off
    cfg_cts_en = 1'b1; cts = 1'b1;
    repeat (4) @(negedge clk);
    exp_frame(9'h05A, 1, 0, 0, ea, na);
    exp_frame(9'h0A3, 1, 0, 0, eb, nb);
    wr(9'h05A);
    repeat (100) @(negedge clk);
    chk("R9 held by CTS line", 64'(txd), 64'd1);
    chk("R9 word still buffered", 64'(buf_empty), 64'd0);
    chk("R9 register empty while held", 64'(reg_empty), 64'd1);
    cts = 1'b0;
    wait_start(w);
    chk("R9 start three edges after CTS low", 64'(w), 64'd3);
    wr(9'h0A3);
    cts = 1'b1;
    capture(na, 16, 7, got);
    chk("R9 frame in progress completes", got & lowmask(na), ea & lowmask(na));
    hi_low = 0;
    repeat (48) begin
      @(negedge clk);
      if (txd !== 1'b1) hi_low++;
    end
    chk("R9 next frame held at stop boundary", 64'(hi_low), 64'd0);
    chk("R9 register empty at hold", 64'(reg_empty), 64'd1);
    chk("R9 buffer still full", 64'(buf_empty), 64'd0);
    cts = 1'b0;
    wait_start(w);
    chk("R9 release latency", 64'(w), 64'd3);
    capture(nb, 16, 8, got);
    chk("R9 held word sent", got & lowmask(nb), eb & lowmask(nb));
    repeat (16) @(negedge clk);
    cfg_cts_en = 1'b0;

    // R10 transmit disable
    exp_frame(9'h099, 1, 0, 0, ea, na);
    exp_frame(9'h066, 1, 0, 0, eb, nb);
    wr(9'h099);
    wait_start(w);
    wr(9'h066);
    cfg_tx_en = 1'b0;
    capture(na, 16, 7, got);
    chk("R10 current frame completes", got & lowmask(na), ea & lowmask(na));
    hi_low = 0;
    repeat (48) begin
      @(negedge clk);
      if (txd !== 1'b1) hi_low++;
    end
    chk("R10 no frame while disabled", 64'(hi_low), 64'd0);
    chk("R10 word waits in buffer", 64'(buf_empty), 64'd0);
    cfg_tx_en = 1'b1;
    wait_start(w);
    chk("R10 resumes one edge after enable", 64'(w), 64'd1);
    capture(nb, 16, 8, got);
    chk("R10 waiting word sent", got & lowmask(nb), eb & lowmask(nb));
    repeat (16) @(negedge clk);

    // R11 interrupt on buffer empty
    cfg_irq_sel = 1'b0;
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R11 cleared", 64'(irq), 64'd0);
    wr(9'h021);
    chk("R11 not yet raised", 64'(irq), 64'd0);
    wait_start(w);
    chk("R11 raised at transfer", 64'(irq), 64'd1);
    repeat (50) @(negedge clk);
    chk("R11 sticky until cleared", 64'(irq), 64'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R11 clear works", 64'(irq), 64'd0);
    while (!reg_empty) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 shifter empty ignored when sel=0", 64'(irq), 64'd0);

    // R11 interrupt on shifter empty
    cfg_irq_sel = 1'b1;
    wr(9'h042);
    wait_start(w);
    chk("R11 no raise at transfer when sel=1", 64'(irq), 64'd0);
    hi_low = 0;
    while (!reg_empty) begin
      if (irq) hi_low++;
      @(negedge clk);
    end
    chk("R11 quiet while shifting", 64'(hi_low), 64'd0);
    chk("R11 raised with register empty", 64'(irq), 64'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R11 cleared after sel=1 event", 64'(irq), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule